// File: doc/BRIEF.md
# LIN Transceiver Operating Mode Controller

This block is the digital mode manager of a LIN transceiver that carries its own low-drop supply regulator. It tracks five operating modes: OFF (unpowered), SAFE (fail-safe), RUN (normal), QUIET (silent) and DORMANT (sleep). From the enable and transmit-data pins and four comparator flags, it decides which mode applies. The four flags report supply-operation, supply-undervoltage, regulator-undervoltage and a filtered bus wake-up. From the mode it drives the regulator enable, the transmit path enable, the termination enable, the receive pin level and the transmit pin turnaround. It also times the open-drain reset.

Named transitions:
- OFF->SAFE on power-up.
- SAFE->RUN when enable is high.
- RUN->QUIET or RUN->DORMANT on an enable falling edge, chosen by the transmit level.
- RUN->SAFE on supply undervoltage or reset loss.
- QUIET->SAFE and DORMANT->SAFE on a wake-up.
- QUIET->RUN on enable.
- SAFE->QUIET or SAFE->DORMANT after an undervoltage exit.
- Any mode ->OFF on loss of supply operation.

In SAFE the transmit and receive pins report why the device left its previous mode. All pin and flag inputs pass through two-flop synchronizers. Delays are counted on a 1 MHz reference clock.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode is OFF (mode code 0) with the regulator off and reset low; once supply-operation is seen, the mode becomes SAFE (code 1) with the regulator and termination on.
- R2: SAFE and QUIET move to RUN (code 2) only with enable high, supply undervoltage absent and reset released; no mode change is taken while reset is held low.
- R3: In RUN an enable falling edge with transmit-data high selects QUIET (code 3): regulator on, transmit path off, receive output high, termination off.
- R4: In RUN an enable falling edge with transmit-data low selects DORMANT (code 4): regulator off, receive output low, reset output low.
- R5: Supply undervoltage in RUN forces SAFE and is reported as transmit driven high and receive low.
- R6: Regulator undervoltage in RUN pulls reset low and forces SAFE, with no source reported (transmit not driven, receive high).
- R7: A bus wake-up in QUIET or DORMANT forces SAFE and is reported as transmit driven low and receive low; a wake report takes priority over an undervoltage report.
- R8: Reset stays low until the regulator has been enabled and free of undervoltage for RESET_CYC consecutive cycles, then goes high.
- R9: The reported source flags clear once the device is in RUN.
- R10: In SAFE entered from RUN by supply undervoltage, an enable falling edge selects QUIET (transmit high) or DORMANT (transmit low).
- R11: In DORMANT a supply undervoltage has no effect; loss of supply-operation returns any mode to OFF.
- R12: In RUN the transmit path and termination are on and the receive output follows the bus receive level.
- R13: An enable edge reaches the mode exactly three clock edges after it is applied: two synchronizer stages and the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| en_i | input | 1 | Enable pin level |
| txd_i | input | 1 | Transmit-data pin level |
| vs_ok_i | input | 1 | Supply above operation threshold |
| vs_uv_i | input | 1 | Supply undervoltage flag |
| vcc_uv_i | input | 1 | Regulator output undervoltage flag |
| bus_wake_i | input | 1 | Filtered bus wake-up event |
| bus_rx_i | input | 1 | Bus receiver comparator level |
| reg_en_o | output | 1 | Regulator enable |
| tx_path_en_o | output | 1 | Transmit path enable |
| rxd_o | output | 1 | Receive pin level |
| txd_drive_o | output | 1 | Transmit pin output-drive request |
| txd_out_o | output | 1 | Transmit pin driven value |
| term_en_o | output | 1 | Bus termination enable |
| nres_o | output | 1 | Reset release (low = reset asserted) |
| mode_o | output | 3 | Current mode code |

## Verification
A pin or flag change reaches the mode three clock edges after it is applied. A regulator undervoltage takes one edge more, because it first clears the reset timer. Mode-dependent outputs follow the mode in the same cycle. Reset rises RESET_CYC edges after the regulator enable and a clean regulator flag.

The bench drives every input on a falling edge. It counts whole cycles to these due points, and samples on a later falling edge. For R13 it samples one cycle before and at the exact edge. Timer checks are taken a few cycles either side of the release point.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_SAFE    = 3'd1,
        MD_RUN     = 3'd2,
        MD_QUIET   = 3'd3,
        MD_DORMANT = 3'd4
    } lmc_mode_e;

    localparam int NUM_IN   = 6;
    localparam int IDX_EN   = 0;
    localparam int IDX_TXD  = 1;
    localparam int IDX_VSOK = 2;
    localparam int IDX_VSUV = 3;
    localparam int IDX_CCUV = 4;
    localparam int IDX_WAKE = 5;
endpackage

// File: rtl/lmc_sync.sv
module lmc_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/lmc_hold_timer.sv
module lmc_hold_timer #(
    parameter int HOLD_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic done_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (clear_i) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (cnt == LAST) done_o <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
    parameter int RESET_CYC   = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       vs_ok_i,
    input  logic       vs_uv_i,
    input  logic       vcc_uv_i,
    input  logic       bus_wake_i,
    input  logic       bus_rx_i,
    output logic       reg_en_o,
    output logic       tx_path_en_o,
    output logic       rxd_o,
    output logic       txd_drive_o,
    output logic       txd_out_o,
    output logic       term_en_o,
    output logic       nres_o,
    output logic [2:0] mode_o
);
    import lmc_pkg::*;

    logic [NUM_IN-1:0] raw, syn;
    logic en_s, txd_s, vs_ok_s, vs_uv_s, vcc_uv_s, wake_s;
    logic en_q, en_fall, hold_done, tmr_clear;
    lmc_mode_e st, st_nx;
    logic wake_f, uv_f, wake_nx, uv_nx;

    assign raw[IDX_EN]   = en_i;
    assign raw[IDX_TXD]  = txd_i;
    assign raw[IDX_VSOK] = vs_ok_i;
    assign raw[IDX_VSUV] = vs_uv_i;
    assign raw[IDX_CCUV] = vcc_uv_i;
    assign raw[IDX_WAKE] = bus_wake_i;

    lmc_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign en_s     = syn[IDX_EN];
    assign txd_s    = syn[IDX_TXD];
    assign vs_ok_s  = syn[IDX_VSOK];
    assign vs_uv_s  = syn[IDX_VSUV];
    assign vcc_uv_s = syn[IDX_CCUV];
    assign wake_s   = syn[IDX_WAKE];
    assign en_fall  = en_q & ~en_s;

    // Reset timer restarts whenever the regulator is off or sagging
    assign tmr_clear = ~reg_en_o | vcc_uv_s;

    lmc_hold_timer #(.HOLD_CYC(RESET_CYC)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .done_o  (hold_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= MD_OFF;
            wake_f <= 1'b0;
            uv_f   <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            st     <= st_nx;
            wake_f <= wake_nx;
            uv_f   <= uv_nx;
            en_q   <= en_s;
        end
    end

    // Transitions
    always_comb begin
        st_nx   = st;
        wake_nx = wake_f;
        uv_nx   = uv_f;
        if (!vs_ok_s) begin
            st_nx   = MD_OFF;
            wake_nx = 1'b0;
            uv_nx   = 1'b0;
        end else begin
            unique case (st)
                MD_OFF: st_nx = MD_SAFE;
                MD_SAFE: begin
                    if (hold_done) begin
                        if (en_fall && uv_f)
                            st_nx = txd_s ? MD_QUIET : MD_DORMANT;
                        else if (en_s && !vs_uv_s)
                            st_nx = MD_RUN;
                    end
                end
                MD_RUN: begin
                    wake_nx = 1'b0;
                    uv_nx   = 1'b0;
                    if (vs_uv_s) begin
                        st_nx = MD_SAFE;
                        uv_nx = 1'b1;
                    end else if (!hold_done) begin
                        st_nx = MD_SAFE;
                    end else if (en_fall) begin
                        st_nx = txd_s ? MD_QUIET : MD_DORMANT;
                    end
                end
                MD_QUIET: begin
                    if (!hold_done) begin
                        st_nx = MD_SAFE;
                    end else if (wake_s) begin
                        st_nx   = MD_SAFE;
                        wake_nx = 1'b1;
                    end else if (en_s && !vs_uv_s) begin
                        st_nx = MD_RUN;
                    end
                end
                MD_DORMANT: begin
                    if (wake_s) begin
                        st_nx   = MD_SAFE;
                        wake_nx = 1'b1;
                    end
                end
                default: st_nx = MD_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_en_o     = 1'b0;
        tx_path_en_o = 1'b0;
        rxd_o        = 1'b0;
        txd_drive_o  = 1'b0;
        txd_out_o    = 1'b1;
        term_en_o    = 1'b0;
        unique case (st)
            MD_OFF: ;
            MD_SAFE: begin
                reg_en_o    = 1'b1;
                term_en_o   = 1'b1;
                rxd_o       = ~(wake_f | uv_f);
                txd_drive_o = wake_f | uv_f;
                txd_out_o   = ~wake_f;
            end
            MD_RUN: begin
                reg_en_o     = 1'b1;
                tx_path_en_o = 1'b1;
                term_en_o    = 1'b1;
                rxd_o        = bus_rx_i;
            end
            MD_QUIET: begin
                reg_en_o = 1'b1;
                rxd_o    = 1'b1;
            end
            MD_DORMANT: ;
            default: ;
        endcase
    end

    assign nres_o = hold_done;
    assign mode_o = st;
endmodule

// File: rtl/lmc_chk.sv
module lmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       reg_en,
    input logic       tx_path,
    input logic       rxd,
    input logic       txd_drive,
    input logic       term,
    input logic       nres
);
    p_quiet_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd3 |-> reg_en && rxd && !tx_path && !term);

    p_dormant_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd4 |-> !reg_en && !rxd);

    p_dormant_nres_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && $past(mode) == 3'd4) |-> !nres);

    p_run_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && $past(mode) != 3'd2) |-> nres);

    p_nres_needs_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> !nres);

    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd0 |-> !reg_en && !term && !tx_path);

    p_report_rx_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && txd_drive) |-> !rxd);

    p_tx_path_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_path |-> term && reg_en);
endmodule

bind lin_mode_ctrl lmc_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_o),
    .reg_en    (reg_en_o),
    .tx_path   (tx_path_en_o),
    .rxd       (rxd_o),
    .txd_drive (txd_drive_o),
    .term      (term_en_o),
    .nres      (nres_o)
);

// File: tb/lin_mode_ctrl_tb_top.sv
module lin_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 1000;
    localparam int RC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, txd_i = 1'b1, vs_ok_i = 1'b0, vs_uv_i = 1'b0;
    logic vcc_uv_i = 1'b0, bus_wake_i = 1'b0, bus_rx_i = 1'b1;
    logic reg_en_o, tx_path_en_o, rxd_o, txd_drive_o, txd_out_o, term_en_o, nres_o;
    logic [2:0] mode_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_mode_ctrl #(.RESET_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .txd_i(txd_i),
        .vs_ok_i(vs_ok_i), .vs_uv_i(vs_uv_i), .vcc_uv_i(vcc_uv_i),
        .bus_wake_i(bus_wake_i), .bus_rx_i(bus_rx_i),
        .reg_en_o(reg_en_o), .tx_path_en_o(tx_path_en_o), .rxd_o(rxd_o),
        .txd_drive_o(txd_drive_o), .txd_out_o(txd_out_o),
        .term_en_o(term_en_o), .nres_o(nres_o), .mode_o(mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Mode expected after an enable falling edge (QUIET=3, DORMANT=4)
    function automatic int exp_low_mode(input logic txd);
        return txd ? 3 : 4;
    endfunction

    task automatic wake_to_run();
        bus_wake_i = 1'b1;
        tick(3);
        bus_wake_i = 1'b0;
        chk("R7 wake->SAFE", mode_o, 1);
        chk("R7 txd driven", txd_drive_o, 1);
        chk("R7 txd low", txd_out_o, 0);
        chk("R7 rxd low", rxd_o, 0);
        en_i = 1'b1;
        tick(RC + 6);
        chk("R2 back to RUN", mode_o, 2);
        chk("R9 flags cleared", txd_drive_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(2);
        chk("R1 reset mode", mode_o, 0);
        chk("R1 reset reg", reg_en_o, 0);
        chk("R1 reset nres", nres_o, 0);
        rst_n = 1'b1;
        tick(1);
        vs_ok_i = 1'b1;
        tick(3);
        chk("R1 power-up SAFE", mode_o, 1);
        chk("R1 reg on", reg_en_o, 1);
        chk("R1 term on", term_en_o, 1);
        en_i = 1'b1;
        tick(RC - 4);
        chk("R2 held in SAFE", mode_o, 1);
        chk("R8 nres still low", nres_o, 0);
        tick(8);
        chk("R8 nres released", nres_o, 1);
        chk("R2 SAFE->RUN", mode_o, 2);

        // R12: receive follows bus in RUN
        for (int i = 0; i < 20; i++) begin
            bus_rx_i = 1'($urandom_range(0, 1));
            tick(1);
            chk("R12 rxd follows", rxd_o, bus_rx_i);
            chk("R12 tx path", tx_path_en_o, 1);
        end
        bus_rx_i = 1'b1;

        // R3 / R13: enable fall with txd high
        txd_i = 1'b1;
        en_i = 1'b0;
        tick(2);
        chk("R13 not yet", mode_o, 2);
        tick(1);
        chk("R13 R3 QUIET", mode_o, 3);
        chk("R3 rxd high", rxd_o, 1);
        chk("R3 reg on", reg_en_o, 1);
        chk("R3 term off", term_en_o, 0);

        // R7 from QUIET, then R9 on re-entry
        bus_wake_i = 1'b1;
        tick(3);
        bus_wake_i = 1'b0;
        chk("R7 QUIET wake", mode_o, 1);
        chk("R7 txd drive", txd_drive_o, 1);
        chk("R7 txd low", txd_out_o, 0);
        chk("R7 rxd low", rxd_o, 0);
        en_i = 1'b1;
        tick(3);
        chk("R2 wake SAFE->RUN", mode_o, 2);
        chk("R9 drive cleared", txd_drive_o, 0);

        // R4: enable fall with txd low
        txd_i = 1'b0;
        en_i = 1'b0;
        tick(4);
        chk("R4 DORMANT", mode_o, 4);
        chk("R4 reg off", reg_en_o, 0);
        chk("R4 rxd low", rxd_o, 0);
        chk("R4 nres low", nres_o, 0);

        // R11: undervoltage ignored in DORMANT
        vs_uv_i = 1'b1;
        tick(6);
        chk("R11 DORMANT ignores uv", mode_o, 4);
        chk("R11 reg stays off", reg_en_o, 0);
        vs_uv_i = 1'b0;
        txd_i = 1'b1;
        wake_to_run();

        // R5 / R10: undervoltage exit then random low-power choice
        for (int k = 0; k < 4; k++) begin
            logic t;
            vs_uv_i = 1'b1;
            tick(3);
            chk("R5 uv->SAFE", mode_o, 1);
            chk("R5 txd drive", txd_drive_o, 1);
            chk("R5 txd high", txd_out_o, 1);
            chk("R5 rxd low", rxd_o, 0);
            tick(2);
            chk("R2 uv blocks RUN", mode_o, 1);
            t = (k < 2) ? 1'(k) : 1'($urandom_range(0, 1));
            txd_i = t;
            en_i = 1'b0;
            tick(3);
            chk("R10 low-power choice", mode_o, exp_low_mode(t));
            vs_uv_i = 1'b0;
            if (t) begin
                en_i = 1'b1;
                tick(3);
                chk("R2 QUIET->RUN", mode_o, 2);
            end else begin
                txd_i = 1'b1;
                tick(1);
                wake_to_run();
            end
        end

        // R6: regulator undervoltage
        vcc_uv_i = 1'b1;
        tick(4);
        chk("R6 SAFE", mode_o, 1);
        chk("R6 nres low", nres_o, 0);
        chk("R6 no report", txd_drive_o, 0);
        chk("R6 rxd high", rxd_o, 1);
        vcc_uv_i = 1'b0;
        tick(RC + 6);
        chk("R6 R2 recovered", mode_o, 2);

        // R11: loss of supply operation
        vs_ok_i = 1'b0;
        tick(3);
        chk("R11 OFF", mode_o, 0);
        chk("R11 reg off", reg_en_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule